// File: doc/BRIEF.md
# Bulk-in Ethernet Record Deframer

A single bulk-in transfer can carry several received Ethernet frames back to back. Each frame is stored as a record: a 32-bit status word, sent least-significant byte first, followed by the frame bytes. The frame bytes include a 4-byte CRC at the end. Padding follows each record, so that the next status word starts at an offset from the start of the transfer that is a multiple of 4. This block walks such a transfer one byte at a time. It delivers each frame's payload, without the CRC, on a byte stream with start and end markers. It stops with a sticky error flag when the transfer is malformed.

A transfer is opened by a one-cycle `xfer_go` pulse that carries the transfer's byte count. The transfer bytes then arrive on `in_valid`/`in_data`, and `in_last` marks the final byte. The byte count, not `in_last`, decides where records end. After an error the block discards input until `in_last`. A transfer that ends exactly at a record boundary, or inside the padding after a record, ends cleanly with a `xfer_done` pulse.

Top module: `usb_rx_deframer`

## Requirements
- R1: After reset `out_valid`, `busy`, `xfer_done` and all four error flags are 0.
- R2: The status word is assembled little-endian. Its bits 29:16 give the record length L, and bits 31:30 and 14:0 other than bit 15 are ignored. The first L-4 body bytes are delivered in order, one per `out_valid` cycle. `out_sof` marks the first of them and `out_eof` the last (both on one byte when L=5). A record with L of 4 or less delivers nothing.
- R3: The last 4 body bytes (the CRC) and the padding bytes are consumed without asserting `out_valid`.
- R4: After a record, the next status word is read at the next offset from the start of the transfer that is a multiple of 4.
- R5: If status bit 15 is set, `err_status` is raised and nothing further of that transfer is delivered.
- R6: If 1 to 3 bytes remain where a status word is expected, `err_short` is raised and nothing further is delivered.
- R7: If L exceeds the bytes remaining after the status word, `err_oversize` is raised and none of that record is delivered.
- R8: A byte count above MAX_XFER (2048) raises `err_count` and nothing is delivered. A count of exactly 2048 is processed normally.
- R9: When the remaining count reaches zero at a record boundary, or inside padding, the block pulses `xfer_done` once and drops `busy` in the same cycle. A count of 0 gives `xfer_done` with no output.
- R10: `xfer_go` is ignored while `busy` is 1.
- R11: Error flags stay set after the transfer ends and are cleared only by the next accepted `xfer_go`. At most one of them is set at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_go | input | 1 | One-cycle pulse that opens a transfer |
| xfer_bytes | input | CNT_W | Transfer byte count, sampled with `xfer_go` |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final byte of the transfer |
| out_valid | output | 1 | Payload byte valid |
| out_data | output | 8 | Payload byte |
| out_sof | output | 1 | First payload byte of a frame |
| out_eof | output | 1 | Last payload byte of a frame |
| busy | output | 1 | A transfer is being walked or drained |
| xfer_done | output | 1 | Pulse on clean end of transfer |
| err_status | output | 1 | Record status reported an error |
| err_short | output | 1 | Incomplete status word |
| err_oversize | output | 1 | Record length exceeds remaining bytes |
| err_count | output | 1 | Byte count above MAX_XFER |

## Verification
Single records are swept over every length from 0 to 12. These tell apart the no-payload lengths, the one-byte frame, and each of the four padding amounts. Two-record transfers are swept over first-record lengths 0 to 11 against several second-record lengths. A misplaced realignment then shows up as wrong bytes or a spurious error. Three-record transfers end inside trailing padding. Each error kind is provoked after a good frame has already been delivered, so the cut-off point can be seen. The byte count is tried at 2048 and 2049, and a stray `xfer_go` is applied mid-transfer.

// File: rtl/usb_rx_deframer.sv
module usb_rx_deframer #(
  parameter int MAX_XFER = 2048,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_go,
  input  logic [CNT_W-1:0] xfer_bytes,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_sof,
  output logic             out_eof,
  output logic             busy,
  output logic             xfer_done,
  output logic             err_status,
  output logic             err_short,
  output logic             err_oversize,
  output logic             err_count
);
  localparam int LEN_W   = 14;
  localparam int LEN_LSB = 16;
  localparam int ERR_BIT = 15;
  localparam int CRC_B   = 4;

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_BODY, S_PAD, S_DRAIN} st_t;
  st_t st;

  logic [CNT_W-1:0] rem;
  logic [1:0]       off, hcnt;
  logic [23:0]      hdr;
  logic [LEN_W-1:0] blen, bcnt;

  wire [31:0]      word      = {in_data, hdr};
  wire [LEN_W-1:0] flen      = word[LEN_LSB +: LEN_W];
  wire [CNT_W-1:0] rem_n     = rem - CNT_W'(1);
  wire             aligned_n = (off + 2'd1) == 2'd0;
  wire             pay       = ({1'b0, bcnt} + (LEN_W+1)'(CRC_B)) < {1'b0, blen};
  wire             last_pay  = ({1'b0, bcnt} + (LEN_W+1)'(CRC_B + 1)) == {1'b0, blen};
  wire             body_end  = (bcnt + LEN_W'(1)) == blen;
  wire             too_big   = 32'(xfer_bytes) > 32'(MAX_XFER);
  wire             flen_big  = 32'(flen) > 32'(rem_n);

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      rem          <= '0;
      off          <= '0;
      hcnt         <= '0;
      hdr          <= '0;
      blen         <= '0;
      bcnt         <= '0;
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_sof      <= 1'b0;
      out_eof      <= 1'b0;
      xfer_done    <= 1'b0;
      err_status   <= 1'b0;
      err_short    <= 1'b0;
      err_oversize <= 1'b0;
      err_count    <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      xfer_done <= 1'b0;
      case (st)
        S_IDLE: if (xfer_go) begin
          err_status   <= 1'b0;
          err_short    <= 1'b0;
          err_oversize <= 1'b0;
          err_count    <= 1'b0;
          rem          <= xfer_bytes;
          off          <= '0;
          hcnt         <= '0;
          if (too_big) begin
            err_count <= 1'b1;
            st        <= S_DRAIN;
          end else if (xfer_bytes == '0) begin
            xfer_done <= 1'b1;
          end else begin
            st <= S_HDR;
          end
        end
        S_HDR: if (in_valid) begin
          rem  <= rem_n;
          off  <= off + 2'd1;
          hcnt <= hcnt + 2'd1;
          hdr  <= {in_data, hdr[23:8]};
          if (hcnt == 2'd0 && rem < CNT_W'(4)) begin
            err_short <= 1'b1;
            st        <= S_DRAIN;
          end else if (hcnt == 2'd3) begin
            if (word[ERR_BIT]) begin
              err_status <= 1'b1;
              st         <= S_DRAIN;
            end else if (flen_big) begin
              err_oversize <= 1'b1;
              st           <= S_DRAIN;
            end else if (rem_n == '0) begin
              xfer_done <= 1'b1;
              st        <= S_IDLE;
            end else if (flen != '0) begin
              blen <= flen;
              bcnt <= '0;
              st   <= S_BODY;
            end
          end
          if (in_last) st <= S_IDLE;
        end
        S_BODY: if (in_valid) begin
          rem  <= rem_n;
          off  <= off + 2'd1;
          bcnt <= bcnt + LEN_W'(1);
          if (pay) begin
            out_valid <= 1'b1;
            out_data  <= in_data;
            out_sof   <= (bcnt == '0);
            out_eof   <= last_pay;
          end
          if (body_end) begin
            if (rem_n == '0) begin
              xfer_done <= 1'b1;
              st        <= S_IDLE;
            end else if (aligned_n) begin
              hcnt <= '0;
              st   <= S_HDR;
            end else begin
              st <= S_PAD;
            end
          end
          if (in_last) st <= S_IDLE;
        end
        S_PAD: if (in_valid) begin
          rem <= rem_n;
          off <= off + 2'd1;
          if (rem_n == '0) begin
            xfer_done <= 1'b1;
            st        <= S_IDLE;
          end else if (aligned_n) begin
            hcnt <= '0;
            st   <= S_HDR;
          end
          if (in_last) st <= S_IDLE;
        end
        S_DRAIN: if (in_valid && in_last) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/usb_rx_deframer_chk.sv
module usb_rx_deframer_chk (
  input logic clk,
  input logic rst_n,
  input logic xfer_go,
  input logic busy,
  input logic out_valid,
  input logic out_sof,
  input logic out_eof,
  input logic xfer_done,
  input logic err_status,
  input logic err_short,
  input logic err_oversize,
  input logic err_count
);
  wire [3:0] errs = {err_count, err_oversize, err_short, err_status};

  // R2
  sof_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);

  // R2
  eof_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> out_valid);

  // R3
  no_data_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);

  // R5
  silent_after_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|errs) |-> !out_valid);

  // R9
  done_clean_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (!busy && errs == 4'd0));

  // R11
  one_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(errs));

  // R11
  errors_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !xfer_go) |=> $stable(errs));
endmodule

bind usb_rx_deframer usb_rx_deframer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_go(xfer_go), .busy(busy),
  .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
  .xfer_done(xfer_done), .err_status(err_status), .err_short(err_short),
  .err_oversize(err_oversize), .err_count(err_count)
);

// File: tb/usb_rx_deframer_tb.sv
`timescale 1ns/100ps
module usb_rx_deframer_tb;
  localparam int MAXX = 2048;
  localparam int BUFN = 2112;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xfer_go = 1'b0;
  logic [15:0] xfer_bytes = '0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_last = 1'b0;
  logic out_valid, out_sof, out_eof, busy, xfer_done;
  logic [7:0] out_data;
  logic err_status, err_short, err_oversize, err_count;

  always #2.5 clk = ~clk;

  usb_rx_deframer u_dut (
    .clk(clk), .rst_n(rst_n), .xfer_go(xfer_go), .xfer_bytes(xfer_bytes),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
    .busy(busy), .xfer_done(xfer_done), .err_status(err_status), .err_short(err_short),
    .err_oversize(err_oversize), .err_count(err_count)
  );

  int total = 0, fails = 0;
  logic [7:0] buff [BUFN];
  int blen_b = 0;
  logic [7:0] gd [BUFN]; logic gs [BUFN]; logic ge [BUFN]; int ng = 0; int ndone = 0;
  logic [7:0] ed [BUFN]; logic es [BUFN]; logic ee [BUFN]; int ne = 0;
  logic [3:0] e_err; logic e_done;

  always @(negedge clk) if (rst_n) begin
    if (out_valid) begin
      gd[ng] = out_data; gs[ng] = out_sof; ge[ng] = out_eof; ng++;
    end
    if (xfer_done) ndone++;
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic put_rec(input int len, input bit bad, input int seed);
    logic [31:0] w;
    w = 32'hC000_1234 | (32'(len) << 16) | (bad ? 32'h8000 : 32'h0);
    for (int i = 0; i < 4; i++) buff[blen_b++] = w[8*i +: 8];
    for (int i = 0; i < len; i++) buff[blen_b++] = 8'((seed * 37 + i * 11 + 1) & 8'hFF);
    while (blen_b % 4 != 0) buff[blen_b++] = 8'hEE;
  endtask

  task automatic model(input int cnt);
    int p, len; logic [31:0] w; bit ok;
    ne = 0; e_err = 4'd0; e_done = 1'b0;
    if (cnt > MAXX) begin e_err[3] = 1'b1; return; end
    p = 0; ok = 1'b1;
    while (ok && p < cnt) begin
      if (cnt - p < 4) begin e_err[1] = 1'b1; ok = 1'b0; end
      else begin
        w = {buff[p+3], buff[p+2], buff[p+1], buff[p]};
        len = int'(w[29:16]);
        if (w[15]) begin e_err[0] = 1'b1; ok = 1'b0; end
        else if (len > cnt - p - 4) begin e_err[2] = 1'b1; ok = 1'b0; end
        else begin
          for (int i = 0; i < len - 4; i++) begin
            ed[ne] = buff[p+4+i]; es[ne] = (i == 0); ee[ne] = (i == len - 5); ne++;
          end
          p = p + 4 + len;
          p = (p + 3) & ~3;
        end
      end
    end
    e_done = ok;
  endtask

  task automatic run(input int cnt, input int nsend, input string tag, input int go_at = -1);
    int bad;
    ng = 0; ndone = 0;
    @(negedge clk);
    xfer_go = 1'b1; xfer_bytes = 16'(cnt);
    @(negedge clk);
    xfer_go = 1'b0;
    for (int i = 0; i < nsend; i++) begin
      in_valid = 1'b1; in_data = buff[i]; in_last = (i == nsend - 1);
      if (i == go_at) begin xfer_go = 1'b1; xfer_bytes = 16'd7; end
      @(negedge clk);
      xfer_go = 1'b0;
    end
    in_valid = 1'b0; in_last = 1'b0;
    repeat (3) @(negedge clk);
    model(cnt);
    chk(ng == ne, tag, "payload byte count", ng, ne);
    bad = 0;
    for (int i = 0; i < ne && i < ng; i++)
      if (gd[i] != ed[i] || gs[i] != es[i] || ge[i] != ee[i]) bad++;
    chk(bad == 0, tag, "payload byte/marker mismatches", bad, 0);
    chk({err_count, err_oversize, err_short, err_status} == e_err, tag, "error flags",
        int'({err_count, err_oversize, err_short, err_status}), int'(e_err));
    chk(ndone == int'(e_done), tag, "done pulses", ndone, int'(e_done));
    chk(busy == 1'b0, tag, "busy at end", int'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!out_valid && !busy && !xfer_done, "R1", "outputs in reset", int'({out_valid, busy, xfer_done}), 0);
    chk({err_count, err_oversize, err_short, err_status} == 4'd0, "R1", "errors in reset",
        int'({err_count, err_oversize, err_short, err_status}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3: single records of every small length, count ends after the body
    for (int len = 0; len <= 12; len++) begin
      blen_b = 0; put_rec(len, 1'b0, len);
      run(4 + len, 4 + len, "R2");
    end
    // R4: two records with realignment between them
    for (int l1 = 0; l1 <= 11; l1++)
      for (int k = 0; k < 4; k++) begin
        blen_b = 0; put_rec(l1, 1'b0, l1); put_rec(5 + k * 2, 1'b0, 50 + k);
        run(blen_b - ((4 - ((5 + k * 2) % 4)) % 4), blen_b - ((4 - ((5 + k * 2) % 4)) % 4), "R4");
      end
    // R9: three records, count ends inside trailing padding; zero count
    blen_b = 0; put_rec(9, 1'b0, 3); put_rec(6, 1'b0, 4); put_rec(13, 1'b0, 5);
    run(blen_b - 1, blen_b - 1, "R9");
    run(0, 0, "R9");
    // R5: error flag on second record
    blen_b = 0; put_rec(8, 1'b0, 7); put_rec(10, 1'b1, 8); put_rec(6, 1'b0, 9);
    run(blen_b, blen_b, "R5");
    // R6: 1..3 stray bytes where a status word is expected
    for (int x = 1; x <= 3; x++) begin
      blen_b = 0; put_rec(7, 1'b0, 10 + x); put_rec(4, 1'b0, 0);
      run(12 + x, 12 + x, "R6");
    end
    // R7: second record longer than what remains
    blen_b = 0; put_rec(6, 1'b0, 20); put_rec(20, 1'b0, 21);
    run(blen_b - 8, blen_b - 8, "R7");
    // R8: over-size count, and exact maximum
    blen_b = 0; put_rec(6, 1'b0, 22);
    run(MAXX + 1, 8, "R8");
    blen_b = 0; put_rec(MAXX - 4, 1'b0, 23);
    run(MAXX, MAXX, "R8");
    // R10: stray go mid-transfer is ignored
    blen_b = 0; put_rec(9, 1'b0, 30); put_rec(5, 1'b0, 31);
    run(blen_b, blen_b, "R10", 5);
    // R11: error stays after transfer end, cleared by next go
    blen_b = 0; put_rec(9, 1'b1, 40);
    run(blen_b, blen_b, "R11");
    repeat (10) @(negedge clk);
    chk(err_status == 1'b1, "R11", "sticky error after idle", int'(err_status), 1);
    blen_b = 0; put_rec(8, 1'b0, 41);
    run(blen_b, blen_b, "R11");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule